// File: doc/BRIEF.md
# Instruction Group Boundary Tracker

This block sits after the decoder and watches a stream of bundles, each carrying three instruction slots in program order (slot 0 first, then 1, then 2). Each slot arrives with a set of already decoded class flags. The block gives every slot the number of the instruction group it belongs to and reports in which slots a group closes and why.

A group closes after any slot that has one of four properties: a stop follows the slot, the slot is a taken branch, it is a break issued from the branch unit, or it raises an illegal-operation fault for a reserved encoding in the branch opcode space. The following leave the group open: breaks from other units, check instructions, return-from-interrupt, long branches and ordinary interruptions. Return-from-interrupt and long branches close a group only because a stop follows them. For these slots, and for other breaks and checks that carry a stop, the block reports a separate reason code. Later dependency logic can then tell a stop after a control transfer apart from a plain stop.

The group number is an 8-bit counter that wraps. It advances once for each group closed by an accepted bundle. The results for a bundle are combinational and appear in the same cycle as the bundle. The handshake passes straight through: the block is ready whenever its consumer is ready.

Top module: `igrp_tracker`

## Requirements
- R1: After a synchronous reset, slot 0 of the next bundle is in group 0.
- R2: Within a bundle, slot i+1 has the group number of slot i plus one if slot i closes a group, and the same number otherwise.
- R3: A stop after a slot, with no other closing or control-transfer flag, raises `grp_end` for that slot with reason 0.
- R4: A taken branch closes the group with reason 1.
- R5: A break from the branch unit closes the group with reason 2.
- R6: A reserved branch-space encoding fault closes the group with reason 3.
- R7: When several closing conditions hold in one slot, the reason is chosen by this priority: reserved fault (3), branch-unit break (2), taken branch (1), then the stop codes.
- R8: Other-unit breaks, checks, return-from-interrupt and long branches without a stop do not raise `grp_end`, and the next slot keeps the same group number.
- R9: A stop on a slot that also carries an other-unit break, check, return-from-interrupt or long branch closes the group with reason 4.
- R10: The group counter advances only when a bundle is accepted (`in_valid` and `out_ready` both high), by the number of groups that bundle closed. `in_ready` follows `out_ready`.
- R11: The group number is 8 bits and wraps from 255 to 0.
- R12: `grp_end` is all zero while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Bundle present |
| in_ready | output | 1 | Bundle accepted this cycle when valid |
| stop_after | input | 3 | Stop follows slot i (bit i) |
| br_taken | input | 3 | Slot is a taken branch |
| brk_branch | input | 3 | Slot is a branch-unit break |
| rsv_fault | input | 3 | Slot faults on a reserved branch-space encoding |
| brk_other | input | 3 | Slot is a break from a non-branch unit |
| chk_op | input | 3 | Slot is a check instruction |
| rfi_op | input | 3 | Slot is a return-from-interrupt |
| long_br | input | 3 | Slot is a long branch |
| out_valid | output | 1 | Results valid |
| out_ready | input | 1 | Consumer takes results |
| slot_gid | output | 24 | Group number of slot i at bits [8i+7:8i] |
| grp_end | output | 3 | Group closes after slot i |
| end_why | output | 9 | Reason code of slot i at bits [3i+2:3i]; 0 when no close |

## Verification
The counter wrap is the case hardest to reach from the ports. Each bundle can close at most three groups, so the bench sends a long run of bundles with a stop on every slot, and the wrap then falls in the middle of a bundle. A stall cycle, with a valid bundle that is full of closing flags, shows that the counter moves only on acceptance. Slots that carry several closing flags at once exercise the reason priority.

// File: rtl/igrp_tracker.sv
module igrp_tracker #(
  parameter int GID_W = 8,
  parameter int NSLOT = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NSLOT-1:0]       stop_after,
  input  logic [NSLOT-1:0]       br_taken,
  input  logic [NSLOT-1:0]       brk_branch,
  input  logic [NSLOT-1:0]       rsv_fault,
  input  logic [NSLOT-1:0]       brk_other,
  input  logic [NSLOT-1:0]       chk_op,
  input  logic [NSLOT-1:0]       rfi_op,
  input  logic [NSLOT-1:0]       long_br,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NSLOT*GID_W-1:0] slot_gid,
  output logic [NSLOT-1:0]       grp_end,
  output logic [3*NSLOT-1:0]     end_why
);
  localparam logic [2:0] WHY_STOP  = 3'd0;
  localparam logic [2:0] WHY_TAKEN = 3'd1;
  localparam logic [2:0] WHY_BRK   = 3'd2;
  localparam logic [2:0] WHY_RSV   = 3'd3;
  localparam logic [2:0] WHY_XSTOP = 3'd4;

  logic [GID_W-1:0] cnt;
  logic [GID_W-1:0] run [NSLOT+1];
  logic [NSLOT-1:0] closes;
  logic             fire;

  assign fire      = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign run[0]    = cnt;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic       xfer;
    logic [2:0] why;
    assign xfer      = brk_other[i] | chk_op[i] | rfi_op[i] | long_br[i];
    assign closes[i] = stop_after[i] | br_taken[i] | brk_branch[i] | rsv_fault[i];
    assign grp_end[i] = in_valid && closes[i];
    assign run[i+1]  = run[i] + GID_W'(closes[i]);
    assign slot_gid[i*GID_W +: GID_W] = run[i];

    always_comb begin
      if (!grp_end[i])        why = WHY_STOP;
      else if (rsv_fault[i])  why = WHY_RSV;
      else if (brk_branch[i]) why = WHY_BRK;
      else if (br_taken[i])   why = WHY_TAKEN;
      else if (xfer)          why = WHY_XSTOP;
      else                    why = WHY_STOP;
    end
    assign end_why[i*3 +: 3] = why;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (fire) cnt <= run[NSLOT];
  end
endmodule

module igrp_tracker_chk #(
  parameter int GID_W = 8,
  parameter int NSLOT = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   out_ready,
  input logic                   out_valid,
  input logic [NSLOT-1:0]       stop_after,
  input logic [NSLOT-1:0]       br_taken,
  input logic [NSLOT-1:0]       brk_branch,
  input logic [NSLOT-1:0]       rsv_fault,
  input logic [NSLOT*GID_W-1:0] slot_gid,
  input logic [NSLOT-1:0]       grp_end,
  input logic [3*NSLOT-1:0]     end_why
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> slot_gid[GID_W-1:0] == '0);

  // R2
  slot_chain_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> slot_gid[2*GID_W-1:GID_W] == slot_gid[GID_W-1:0] + GID_W'(grp_end[0]));

  // R8
  no_close_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !stop_after[0] && !br_taken[0] && !brk_branch[0] && !rsv_fault[0])
      |-> !grp_end[0]);

  // R6
  rsv_why_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_end[0] && rsv_fault[0]) |-> end_why[2:0] == 3'd3);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && out_ready) |=> $stable(slot_gid[GID_W-1:0]));

  // R10
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready) |=> slot_gid[GID_W-1:0] ==
      $past(slot_gid[NSLOT*GID_W-1 -: GID_W] + GID_W'(grp_end[NSLOT-1])));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> grp_end == '0);
endmodule

bind igrp_tracker igrp_tracker_chk #(.GID_W(GID_W), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/sim_igrp_tracker.sv
`timescale 1ns/1ps
module sim_igrp_tracker;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [2:0] stop_after = '0, br_taken = '0, brk_branch = '0, rsv_fault = '0;
  logic [2:0] brk_other = '0, chk_op = '0, rfi_op = '0, long_br = '0;
  logic [23:0] slot_gid;
  logic [2:0]  grp_end;
  logic [8:0]  end_why;

  int checks = 0, errors = 0;
  logic [7:0] exp_cnt = '0;

  typedef struct packed { logic [23:0] g; logic [2:0] e; logic [8:0] w; } item_t;
  item_t exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  igrp_tracker u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] st, tk, bb, rf, bo, ck, ri, lb, input string tag);
    item_t it;
    logic [7:0] g;
    g = exp_cnt;
    for (int i = 0; i < 3; i++) begin
      logic cl;
      logic [2:0] w;
      cl = st[i] | tk[i] | bb[i] | rf[i];
      if (!cl)       w = 3'd0;
      else if (rf[i]) w = 3'd3;
      else if (bb[i]) w = 3'd2;
      else if (tk[i]) w = 3'd1;
      else if (bo[i] | ck[i] | ri[i] | lb[i]) w = 3'd4;
      else w = 3'd0;
      it.g[i*8 +: 8] = g;
      it.e[i] = cl;
      it.w[i*3 +: 3] = w;
      g = g + {7'd0, cl};
    end
    exp_cnt = g;
    stop_after = st; br_taken = tk; brk_branch = bb; rsv_fault = rf;
    brk_other = bo; chk_op = ck; rfi_op = ri; long_br = lb;
    in_valid = 1'b1; out_ready = 1'b1;
    exp_q.push_back(it);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && in_valid && out_ready && exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " out_valid"}, 64'(out_valid), 64'd1);
      check({t, " gid"}, 64'(slot_gid), 64'(e.g));
      check({t, " end"}, 64'(grp_end), 64'(e.e));
      check({t, " why"}, 64'(end_why), 64'(e.w));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 gid0 after reset", 64'(slot_gid[7:0]), 64'd0);
    @(posedge clk); #1;

    send(3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R2 R8 quiet bundle");
    send(3'b010, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R3 stop slot1");
    send(3'b000, 3'b001, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R4 taken slot0");
    send(3'b000, 3'b000, 3'b100, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R5 branch break slot2");
    send(3'b000, 3'b010, 3'b000, 3'b010, 3'b000, 3'b000, 3'b000, 3'b000, "R6 R7 reserved fault over taken");
    send(3'b001, 3'b001, 3'b001, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R7 break over taken and stop");
    send(3'b100, 3'b100, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R7 taken over stop");
    send(3'b000, 3'b000, 3'b000, 3'b000, 3'b001, 3'b010, 3'b100, 3'b001, "R8 non-closing transfers");
    send(3'b101, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b001, 3'b100, "R9 rfi and long branch with stop");
    send(3'b010, 3'b000, 3'b000, 3'b000, 3'b010, 3'b010, 3'b000, 3'b000, "R9 check and break with stop");

    // R10: valid bundle full of closers but consumer stalls
    stop_after = 3'b111; br_taken = 3'b111; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R10 in_ready follows out_ready", 64'(in_ready), 64'd0);
    check("R10 gid before stall edge", 64'(slot_gid[7:0]), 64'(exp_cnt));
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 gid held after stall", 64'(slot_gid[7:0]), 64'(exp_cnt));
    check("R12 no end when idle", 64'(grp_end), 64'd0);
    @(posedge clk); #1;
    stop_after = '0; br_taken = '0;

    // R11: many groups per bundle force the 8-bit wrap
    for (int k = 0; k < 90; k++)
      send(3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R11 wrap run");
    send(3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R2 after wrap");

    @(posedge clk);
    @(negedge clk);
    check("R11 queue drained", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule